// File: doc/BRIEF.md
# Saturating SIMD Pack Unit

This block narrows packed integer lanes. It takes two 64-bit operands, a destination and a source, and clamps every lane of both to a type half as wide. It then packs the clamped lanes into one 64-bit result. Three narrowing modes are available: signed 32-bit to signed 16-bit, signed 16-bit to signed 8-bit, and signed 16-bit to unsigned 8-bit. The caller delivers the source operand ready to use, from a register or from memory. Instruction decode, address generation and the register file belong to the surrounding pipeline.

The result and its valid flag are registered. An operation presented in one cycle appears at the outputs after the next rising clock edge. A new operation may be issued every cycle. The operation select reuses bits [3:2] of the second opcode byte of the three pack instructions, so a decoder can pass those bits through unchanged. The fourth select code is not an operation. It returns a zero result with valid and an illegal-operation flag both set.

Top module: `simd_narrow_pack`

## Requirements
- R1: While rst_ni is low, res_valid_o, res_illegal_o and res_data_o are all zero, whatever the inputs.
- R2: A cycle with in_valid_i high at a rising edge gives res_valid_o high after that edge. Operations issued in consecutive cycles each produce their own result in consecutive cycles.
- R3: op_sel_i = 2'b00 (opcode byte 63h) turns each signed 16-bit lane into a signed 8-bit lane. Values above 127 become 7Fh, values below -128 become 80h, and all other values keep their low byte.
- R4: op_sel_i = 2'b01 (opcode byte 67h) turns each signed 16-bit lane into an unsigned 8-bit lane. Negative values become 00h, values above 255 become FFh, and values 0 to 255 keep their low byte.
- R5: op_sel_i = 2'b10 (opcode byte 6Bh) turns each signed 32-bit lane into a signed 16-bit lane. Values above 32767 become 7FFFh, values below -32768 become 8000h, and all other values keep their low half.
- R6: Result lane k is the narrowed destination lane k for k below N, and the narrowed source lane k-N otherwise. N is the number of input lanes in one operand: 4 for the byte modes and 2 for the word mode. Destination lanes fill the lower half of the result and source lanes the upper half, each in its own order.
- R7: op_sel_i = 2'b11 with in_valid_i high gives res_data_o = 0, res_valid_o = 1 and res_illegal_o = 1 on the next cycle. A legal select gives res_illegal_o = 0.
- R8: A cycle with in_valid_i low gives res_valid_o = 0 and res_illegal_o = 0 on the next cycle. res_data_o keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operation present this cycle |
| op_sel_i | input | 2 | Narrowing mode: 00 signed to byte, 01 unsigned to byte, 10 signed to word, 11 illegal |
| dst_opnd_i | input | OPND_W | Destination operand, source of the lower result half |
| src_opnd_i | input | OPND_W | Source operand, source of the upper result half |
| res_valid_o | output | 1 | Result valid |
| res_data_o | output | OPND_W | Packed, saturated result |
| res_illegal_o | output | 1 | Result came from the unused select code |

## Verification
The assertions check on every cycle that valid follows its strobe with one cycle of delay, and that the data holds when no operation is issued. They also check that an illegal result is always valid and zero. At the edges of the lanes they check both saturation floors, the 8-bit ceiling and the placement of the top source lane. The clamp value of every lane under mixed patterns can only be shown by the bench's scenarios. So can back-to-back throughput with changing modes and the reset state. The bench compares each result against functions that compute the clamp lane by lane.

// File: rtl/simd_pack_pkg.sv
package simd_pack_pkg;

   // select codes equal bits [3:2] of the second opcode byte (63h, 67h, 6Bh)
   typedef enum logic [1:0] {
      PK_S16_S8  = 2'b00,
      PK_S16_U8  = 2'b01,
      PK_S32_S16 = 2'b10,
      PK_NONE    = 2'b11
   } pack_op_e;

   localparam int unsigned PK_LANE_GRAIN = 32;

endpackage

// File: rtl/simd_sat_lane.sv
module simd_sat_lane #(
   parameter int unsigned IN_W       = 16,
   parameter int unsigned OUT_W      = 8,
   parameter bit          ZERO_FLOOR = 1'b0
) (
   input  logic [IN_W-1:0]  lane_i,
   output logic [OUT_W-1:0] lane_o
);

   localparam int unsigned EXT_W = IN_W - OUT_W;

   if (EXT_W < 2) begin : g_bad_width
      $error("simd_sat_lane: IN_W must exceed OUT_W by at least 2");
   end

   if (ZERO_FLOOR) begin : g_unsigned
      logic neg_l;
      logic big_l;
      assign neg_l  = lane_i[IN_W-1];
      assign big_l  = |lane_i[IN_W-2:OUT_W];
      assign lane_o = neg_l ? '0 : (big_l ? '1 : lane_i[OUT_W-1:0]);
   end else begin : g_signed
      logic [EXT_W:0] head_l;
      logic           fits_l;
      assign head_l = lane_i[IN_W-1:OUT_W-1];
      assign fits_l = (&head_l) | ~(|head_l);
      assign lane_o = fits_l ? lane_i[OUT_W-1:0]
                             : {lane_i[IN_W-1], {(OUT_W-1){~lane_i[IN_W-1]}}};
   end

endmodule

// File: rtl/simd_narrow_row.sv
module simd_narrow_row #(
   parameter int unsigned IN_W       = 16,
   parameter int unsigned N_LANES    = 8,
   parameter bit          ZERO_FLOOR = 1'b0,
   localparam int unsigned OUT_W     = IN_W / 2
) (
   input  logic [N_LANES*IN_W-1:0]  row_i,
   output logic [N_LANES*OUT_W-1:0] row_o
);

   for (genvar g = 0; g < N_LANES; g++) begin : g_lane
      simd_sat_lane #(
         .IN_W      (IN_W),
         .OUT_W     (OUT_W),
         .ZERO_FLOOR(ZERO_FLOOR)
      ) sat_i (
         .lane_i(row_i[g*IN_W +: IN_W]),
         .lane_o(row_o[g*OUT_W +: OUT_W])
      );
   end

endmodule

// File: rtl/simd_narrow_pack.sv
module simd_narrow_pack
   import simd_pack_pkg::*;
#(
   parameter int unsigned OPND_W = 64
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              in_valid_i,
   input  logic [1:0]        op_sel_i,
   input  logic [OPND_W-1:0] dst_opnd_i,
   input  logic [OPND_W-1:0] src_opnd_i,
   output logic              res_valid_o,
   output logic [OPND_W-1:0] res_data_o,
   output logic              res_illegal_o
);

   localparam int unsigned PAIR_W  = 2 * OPND_W;
   localparam int unsigned N_WORDS = PAIR_W / 16;
   localparam int unsigned N_DWRDS = PAIR_W / 32;

   if ((OPND_W % PK_LANE_GRAIN) != 0 || OPND_W == 0) begin : g_bad_opnd
      $error("simd_narrow_pack: OPND_W must be a nonzero multiple of 32");
   end

   // source above destination: lane order carries straight to the result
   logic [PAIR_W-1:0] pair_l;
   assign pair_l = {src_opnd_i, dst_opnd_i};

   logic [OPND_W-1:0] s8_l, u8_l, s16_l;

   simd_narrow_row #(.IN_W(16), .N_LANES(N_WORDS), .ZERO_FLOOR(1'b0)) row_s8_i (
      .row_i(pair_l), .row_o(s8_l));

   simd_narrow_row #(.IN_W(16), .N_LANES(N_WORDS), .ZERO_FLOOR(1'b1)) row_u8_i (
      .row_i(pair_l), .row_o(u8_l));

   simd_narrow_row #(.IN_W(32), .N_LANES(N_DWRDS), .ZERO_FLOOR(1'b0)) row_s16_i (
      .row_i(pair_l), .row_o(s16_l));

   pack_op_e          op_l;
   logic [OPND_W-1:0] nxt_data_l;
   logic              nxt_bad_l;

   assign op_l = pack_op_e'(op_sel_i);

   always_comb begin
      nxt_bad_l = 1'b0;
      unique case (op_l)
         PK_S16_S8:  nxt_data_l = s8_l;
         PK_S16_U8:  nxt_data_l = u8_l;
         PK_S32_S16: nxt_data_l = s16_l;
         default: begin
            nxt_data_l = '0;
            nxt_bad_l  = 1'b1;
         end
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         res_valid_o   <= 1'b0;
         res_illegal_o <= 1'b0;
         res_data_o    <= '0;
      end else begin
         res_valid_o <= in_valid_i;
         if (in_valid_i) begin
            res_data_o    <= nxt_data_l;
            res_illegal_o <= nxt_bad_l;
         end else begin
            res_illegal_o <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/simd_narrow_pack_chk.sv
module simd_narrow_pack_chk #(
   parameter int unsigned OPND_W = 64
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              in_valid_i,
   input logic [1:0]        op_sel_i,
   input logic [OPND_W-1:0] dst_opnd_i,
   input logic [OPND_W-1:0] src_opnd_i,
   input logic              res_valid_o,
   input logic [OPND_W-1:0] res_data_o,
   input logic              res_illegal_o
);

   localparam int unsigned HALF_W = OPND_W / 2;

   p_valid_follows_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      in_valid_i |=> res_valid_o);

   p_idle_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !in_valid_i |=> (!res_valid_o && !res_illegal_o));

   p_idle_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !in_valid_i |=> $stable(res_data_o));

   p_bad_flagged_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (in_valid_i && op_sel_i == 2'b11) |=> (res_illegal_o && res_valid_o && res_data_o == '0));

   p_good_unflagged_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (in_valid_i && op_sel_i != 2'b11) |=> !res_illegal_o);

   p_byte_ceiling_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (in_valid_i && op_sel_i == 2'b00 && $signed(dst_opnd_i[15:0]) > 16'sd127)
      |=> res_data_o[7:0] == 8'h7F);

   p_ubyte_floor_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (in_valid_i && op_sel_i == 2'b01 && dst_opnd_i[15])
      |=> res_data_o[7:0] == 8'h00);

   p_word_floor_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (in_valid_i && op_sel_i == 2'b10 && $signed(dst_opnd_i[31:0]) < -32'sd32768)
      |=> res_data_o[15:0] == 16'h8000);

   p_src_top_lane_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (in_valid_i && op_sel_i == 2'b01 && src_opnd_i[OPND_W-1])
      |=> res_data_o[OPND_W-1 -: 8] == 8'h00);

   p_src_low_lane_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (in_valid_i && op_sel_i == 2'b01 && !src_opnd_i[15] && |src_opnd_i[14:8])
      |=> res_data_o[HALF_W +: 8] == 8'hFF);

endmodule

bind simd_narrow_pack simd_narrow_pack_chk #(.OPND_W(OPND_W)) chk_i (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .in_valid_i   (in_valid_i),
   .op_sel_i     (op_sel_i),
   .dst_opnd_i   (dst_opnd_i),
   .src_opnd_i   (src_opnd_i),
   .res_valid_o  (res_valid_o),
   .res_data_o   (res_data_o),
   .res_illegal_o(res_illegal_o)
);

// File: tb/simd_narrow_pack_tb.sv
`timescale 1ns/1ps
module simd_narrow_pack_tb_top;

   localparam int unsigned W = 64;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [1:0]   op_sel = 2'b00;
   logic [W-1:0] dst_op = '0;
   logic [W-1:0] src_op = '0;
   logic         res_valid;
   logic [W-1:0] res_data;
   logic         res_illegal;

   int checks = 0;
   int errors = 0;
   logic [W-1:0] last_data = '0;

   always #4 clk = ~clk;

   simd_narrow_pack #(.OPND_W(W)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .op_sel_i(op_sel),
      .dst_opnd_i(dst_op), .src_opnd_i(src_op), .res_valid_o(res_valid),
      .res_data_o(res_data), .res_illegal_o(res_illegal));

   function automatic logic [7:0] sat_s8(input logic [15:0] v);
      int x = $signed(v);
      if (x > 127)  return 8'h7F;
      if (x < -128) return 8'h80;
      return v[7:0];
   endfunction

   function automatic logic [7:0] sat_u8(input logic [15:0] v);
      int x = $signed(v);
      if (x < 0)   return 8'h00;
      if (x > 255) return 8'hFF;
      return v[7:0];
   endfunction

   function automatic logic [15:0] sat_s16(input logic [31:0] v);
      longint x = longint'($signed(v));
      if (x > 32767)  return 16'h7FFF;
      if (x < -32768) return 16'h8000;
      return v[15:0];
   endfunction

   function automatic logic [W-1:0] ref_pack(input logic [1:0] op,
                                             input logic [W-1:0] d,
                                             input logic [W-1:0] s);
      logic [W-1:0] r = '0;
      case (op)
         2'b00: for (int i = 0; i < 4; i++) begin
                   r[8*i +: 8]      = sat_s8(d[16*i +: 16]);
                   r[32 + 8*i +: 8] = sat_s8(s[16*i +: 16]);
                end
         2'b01: for (int i = 0; i < 4; i++) begin
                   r[8*i +: 8]      = sat_u8(d[16*i +: 16]);
                   r[32 + 8*i +: 8] = sat_u8(s[16*i +: 16]);
                end
         2'b10: for (int i = 0; i < 2; i++) begin
                   r[16*i +: 16]      = sat_s16(d[32*i +: 32]);
                   r[32 + 16*i +: 16] = sat_s16(s[32*i +: 32]);
                end
         default: r = '0;
      endcase
      return r;
   endfunction

   task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   // drive at a falling edge; result is visible at the following falling edge
   task automatic issue(input string req, input logic [1:0] op,
                        input logic [W-1:0] d, input logic [W-1:0] s);
      logic [W-1:0] exp = ref_pack(op, d, s);
      in_valid = 1'b1; op_sel = op; dst_op = d; src_op = s;
      @(negedge clk);
      check({req, " data"}, res_data, exp);
      check({req, " valid"}, {63'b0, res_valid}, 64'd1);
      check({req, " illegal"}, {63'b0, res_illegal}, {63'b0, op == 2'b11});
      last_data = exp;
   endtask

   function automatic logic [15:0] pick_word();
      case ($urandom % 7)
         0: return 16'h7FFF;
         1: return 16'h8000;
         2: return 16'h007F;
         3: return 16'hFF80;
         4: return 16'h00FF;
         5: return 16'h0100;
         default: return 16'($urandom);
      endcase
   endfunction

   function automatic logic [31:0] pick_dword();
      case ($urandom % 6)
         0: return 32'h0000_7FFF;
         1: return 32'hFFFF_8000;
         2: return 32'h0000_8000;
         3: return 32'hFFFF_7FFF;
         4: return 32'h8000_0000;
         default: return $urandom;
      endcase
   endfunction

   function automatic logic [W-1:0] pick_opnd(input bit dwords);
      logic [W-1:0] v;
      if (dwords) v = {pick_dword(), pick_dword()};
      else        v = {pick_word(), pick_word(), pick_word(), pick_word()};
      return v;
   endfunction

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : stim
      void'($urandom(32'd1234));
      // R1: reset with active inputs
      in_valid = 1'b1; op_sel = 2'b11; dst_op = '1; src_op = '1;
      repeat (3) @(negedge clk);
      check("R1 data", res_data, '0);
      check("R1 valid", {63'b0, res_valid}, '0);
      check("R1 illegal", {63'b0, res_illegal}, '0);
      in_valid = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R3 boundaries
      issue("R3", 2'b00, 64'h0080_FF7F_007F_FF80, 64'h7FFF_8000_0000_FFFF);
      // R4 boundaries
      issue("R4", 2'b01, 64'h0100_00FF_FFFF_0000, 64'h8000_7FFF_0001_0180);
      // R5 boundaries
      issue("R5", 2'b10, 64'hFFFF_8000_0000_7FFF, 64'hFFFF_7FFF_0000_8000);
      // R6: distinct in-range lanes show placement
      issue("R6", 2'b00, 64'h0004_0003_0002_0001, 64'h0008_0007_0006_0005);
      check("R6 order", res_data, 64'h0807_0605_0403_0201);
      issue("R6 word", 2'b10, 64'h0000_2222_0000_1111, 64'h0000_4444_0000_3333);
      check("R6 word order", res_data, 64'h4444_3333_2222_1111);
      // R7 illegal code
      issue("R7", 2'b11, 64'h1234_5678_9ABC_DEF0, 64'hFFFF_FFFF_FFFF_FFFF);
      // R7: illegal flag drops on a legal op right after
      issue("R7 after", 2'b01, 64'h0001_0002_0003_0004, 64'h0);

      // R8: idle with changed inputs
      in_valid = 1'b0; op_sel = 2'b10; dst_op = 64'hDEAD_BEEF_0BAD_F00D; src_op = '1;
      @(negedge clk);
      check("R8 valid", {63'b0, res_valid}, '0);
      check("R8 illegal", {63'b0, res_illegal}, '0);
      check("R8 hold", res_data, last_data);
      // R8 after an illegal result
      issue("R8 prep", 2'b11, 64'h5, 64'h6);
      in_valid = 1'b0;
      @(negedge clk);
      check("R8 illegal clear", {63'b0, res_illegal}, '0);
      check("R8 hold zero", res_data, '0);

      // R2: back-to-back random stream with mixed modes
      for (int n = 0; n < 400; n++) begin
         logic [1:0] op = 2'($urandom % 4);
         issue("R2 stream", op, pick_opnd(op == 2'b10), pick_opnd(op == 2'b10));
      end

      in_valid = 1'b0;
      @(negedge clk);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule